// File: doc/BRIEF.md
# Registered ROM with Selectable Enable Behaviour

This block models a byte-wide read-only memory whose read path ends in a clocked output register. An address presented around a rising clock edge selects a word. That word is captured into the output register at the edge and drives the output bus from then on. The output bus is tri-state, and it is modelled as a data vector plus a drive-valid flag.

A stored control byte sets what the single enable pin does. It can act as an output enable that works at once. It can act as an output enable that is sampled by the clock. Or it can turn the block into one with an asynchronous initialize input. In that last mode, pulling the initialize pin low forces a stored initialize byte into the output register without waiting for the clock.

The array and the two configuration bytes are filled through a valid/ready load port. The load port has one extra address bit. When that bit is clear, the load reaches the data array. When it is set, the load reaches a configuration word.

The depth is `2**ADDR_W` words. The full-size part uses `ADDR_W = 13`, which gives 8192 words. The default is smaller so that the model stays light.

Top module: `cfg_rom_reg`

## Requirements
- R1: While `rst_n` is low, the output register clears to 0x00, the control byte clears to 0x00, and the sampled enable clears to 0. The block therefore leaves reset in the immediate-enable mode, with `dout_oe` equal to `en`.
- R2: A load with `ld_addr[ADDR_W]` = 0 writes `ld_data` into the array word `ld_addr[ADDR_W-1:0]`. A load with `ld_addr[ADDR_W]` = 1 is decoded by its low bits: offset 0 writes the initialize byte, offset 1 writes the control byte, and any other offset is ignored. A configuration load never alters the array.
- R3: The word at `addr` is captured at each rising clock edge and appears on `dout` after that edge. `dout` does not change when `addr` changes between edges.
- R4: With control byte 0x00, `dout_oe` follows `en` without waiting for a clock edge. The level of `en` has no effect on what the output register captures.
- R5: With control byte 0x01, `dout_oe` equals the level that `en` had at the most recent rising clock edge. A change on `en` therefore reaches the bus one edge later.
- R6: With control byte 0x02, `dout_oe` is always 1 and `en` has no effect. While `init_n` is low, `dout` equals the initialize byte at once, including across rising clock edges. After `init_n` returns high, the next edge captures the addressed word again.
- R7: With control byte 0x00 or 0x01, `init_n` has no effect on `dout`.
- R8: A control byte other than 0x00, 0x01 or 0x02 behaves exactly like 0x00.
- R9: `ld_ready` equals `rst_n`. A load is accepted on any rising edge where both `ld_valid` and `ld_ready` are high. The port never applies back-pressure outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Read address |
| en | input | 1 | Multi-purpose enable pin |
| init_n | input | 1 | Active-low initialize (used only in mode 0x02) |
| dout | output | DATA_W | Output register contents |
| dout_oe | output | 1 | 1 when the bus is driven |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load can be accepted |
| ld_addr | input | ADDR_W+1 | Load address; top bit selects the configuration space |
| ld_data | input | DATA_W | Load data |

## Verification
Each fault in the internal state shows up at the ports within one clock edge.

- A wrongly decoded control byte shows on `dout_oe` at the first change of `en`. In the wrong mode, the bus drive either responds without waiting for a clock edge or lags by one edge.
- A stale or wrong output register shows on `dout` on the cycle after the edge that should have captured the addressed word.
- A missing asynchronous path from the initialize pin shows before any edge occurs. If the clock wins over the initialize pin, `dout` shows the addressed word instead of the initialize byte right after the coincident edge.

// File: rtl/rrom_pkg.sv
package rrom_pkg;
  typedef enum logic [1:0] {
    MODE_AOE  = 2'd0,
    MODE_SOE  = 2'd1,
    MODE_INIT = 2'd2
  } rom_mode_e;

  function automatic rom_mode_e decode_ctrl(input logic [7:0] ctrl);
    case (ctrl)
      8'h01:   return MODE_SOE;
      8'h02:   return MODE_INIT;
      default: return MODE_AOE;
    endcase
  endfunction
endpackage

// File: rtl/rrom_store.sv
module rrom_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rrom_cfg.sv
module rrom_cfg #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_fire,
  input  logic [ADDR_W:0]     ld_addr,
  input  logic [DATA_W-1:0]   ld_data,
  output logic                mem_we,
  output logic [DATA_W-1:0]   init_byte,
  output rrom_pkg::rom_mode_e mode
);
  localparam logic [ADDR_W-1:0] OFS_INIT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(1);

  logic       cfg_sel;
  logic [7:0] ctrl_q;

  assign cfg_sel = ld_addr[ADDR_W];
  assign mem_we  = ld_fire && !cfg_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_byte <= '0;
      ctrl_q    <= 8'h00;
    end else if (ld_fire && cfg_sel) begin
      if (ld_addr[ADDR_W-1:0] == OFS_INIT) init_byte <= ld_data;
      if (ld_addr[ADDR_W-1:0] == OFS_CTRL) ctrl_q    <= ld_data[7:0];
    end
  end

  assign mode = rrom_pkg::decode_ctrl(ctrl_q);
endmodule

// File: rtl/rrom_outreg.sv
module rrom_outreg #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rrom_pkg::rom_mode_e mode,
  input  logic                en,
  input  logic                init_n,
  input  logic [DATA_W-1:0]   init_val,
  input  logic [DATA_W-1:0]   d,
  output logic [DATA_W-1:0]   q,
  output logic                oe
);
  logic init_act;
  logic en_q;

  assign init_act = (mode == rrom_pkg::MODE_INIT) && !init_n;

  always_ff @(posedge clk or posedge init_act) begin
    if (init_act)    q <= init_val;
    else if (!rst_n) q <= '0;
    else             q <= d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  always_comb begin
    case (mode)
      rrom_pkg::MODE_SOE:  oe = en_q;
      rrom_pkg::MODE_INIT: oe = 1'b1;
      default:             oe = en;
    endcase
  end
endmodule

// File: rtl/cfg_rom_reg.sv
module cfg_rom_reg #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic              init_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W:0]   ld_addr,
  input  logic [DATA_W-1:0] ld_data
);
  logic                ld_fire;
  logic                mem_we;
  logic [DATA_W-1:0]   init_byte;
  logic [DATA_W-1:0]   rd_word;
  rrom_pkg::rom_mode_e mode;

  assign ld_ready = rst_n;
  assign ld_fire  = ld_valid && ld_ready;

  rrom_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ld_fire(ld_fire), .ld_addr(ld_addr),
    .ld_data(ld_data), .mem_we(mem_we), .init_byte(init_byte), .mode(mode)
  );

  rrom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .wr_en(mem_we), .wr_addr(ld_addr[ADDR_W-1:0]),
    .wr_data(ld_data), .rd_addr(addr), .rd_data(rd_word)
  );

  rrom_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .en(en), .init_n(init_n),
    .init_val(init_byte), .d(rd_word), .q(dout), .oe(dout_oe)
  );
endmodule

// File: rtl/rrom_chk.sv
module rrom_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                init_n,
  input logic [DATA_W-1:0]   dout,
  input logic                dout_oe,
  input rrom_pkg::rom_mode_e mode,
  input logic [DATA_W-1:0]   init_val
);
  // R4
  aoe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == rrom_pkg::MODE_AOE) |-> (dout_oe == en));

  // R5
  soe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode == rrom_pkg::MODE_SOE &&
     $past(mode == rrom_pkg::MODE_SOE)) |-> (dout_oe == $past(en)));

  // R6
  init_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == rrom_pkg::MODE_INIT) |-> dout_oe);

  // R6
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == rrom_pkg::MODE_INIT && !init_n &&
     $past(mode == rrom_pkg::MODE_INIT && !init_n) && $stable(init_val))
    |-> (dout == init_val));
endmodule

bind cfg_rom_reg rrom_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .init_n(init_n), .dout(dout),
  .dout_oe(dout_oe), .mode(mode), .init_val(init_byte)
);

// File: tb/test_cfg_rom_reg.sv
`timescale 1ns/1ps
module test_cfg_rom_reg;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] INIT_B = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          en = 1'b1;
  logic          init_n = 1'b1;
  logic [7:0]    dout;
  logic          dout_oe;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [AW:0]   ld_addr = '0;
  logic [7:0]    ld_data = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_rom_reg #(.ADDR_W(AW), .DATA_W(8)) i_cfg_rom_reg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en(en), .init_n(init_n),
    .dout(dout), .dout_oe(dout_oe), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data)
  );

  function automatic logic [7:0] pat(input int a);
    int v;
    v = (a * 13 + 5) ^ (a >> 3);
    return v[7:0];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_word(input logic [AW:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    load_word({1'b1, AW'(1)}, v);
  endtask

  task automatic read_at(input int a, input string req);
    logic [7:0] prev;
    @(negedge clk);
    prev = dout;
    addr = AW'(a);
    #1 chk({req, " hold between edges"}, dout, prev);
    @(posedge clk);
    #1 chk({req, " registered read"}, dout, pat(a));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b1; init_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 dout cleared", dout, 8'h00);
    chk("R1 default mode drives with en", {7'b0, dout_oe}, 8'h01);
    chk("R9 not ready in reset", {7'b0, ld_ready}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R9 ready after reset", {7'b0, ld_ready}, 8'h01);
  endtask

  task automatic t_load();
    for (int a = 0; a < DEPTH; a++) load_word({1'b0, AW'(a)}, pat(a));
    load_word({1'b1, AW'(0)}, INIT_B);
    set_ctrl(8'h00);
    load_word({1'b1, AW'(2)}, 8'h02);
    read_at(0, "R2 config load leaves word 0");
    read_at(DEPTH - 1, "R2 last word");
    @(negedge clk); en = 1'b0;
    #1 chk("R2 stray offset ignored", {7'b0, dout_oe}, 8'h00);
    en = 1'b1;
  endtask

  task automatic t_async();
    set_ctrl(8'h00);
    read_at(17, "R3 mode0");
    read_at(300, "R3 mode0");
    @(negedge clk); en = 1'b0;
    #1 chk("R4 drive off at once", {7'b0, dout_oe}, 8'h00);
    addr = AW'(5);
    @(posedge clk); #1;
    @(negedge clk); en = 1'b1;
    #1 chk("R4 drive on at once", {7'b0, dout_oe}, 8'h01);
    chk("R4 register kept capturing", dout, pat(5));
    @(negedge clk); init_n = 1'b0; addr = AW'(9);
    #1 chk("R7 init ignored mode0 async", dout, pat(5));
    @(posedge clk); #1 chk("R7 init ignored mode0 edge", dout, pat(9));
    @(negedge clk); init_n = 1'b1;
  endtask

  task automatic t_sync();
    set_ctrl(8'h01);
    read_at(44, "R3 mode1");
    @(negedge clk); en = 1'b0;
    #1 chk("R5 no change before edge", {7'b0, dout_oe}, 8'h01);
    @(posedge clk); #1 chk("R5 off after edge", {7'b0, dout_oe}, 8'h00);
    @(negedge clk); en = 1'b1;
    #1 chk("R5 still off before edge", {7'b0, dout_oe}, 8'h00);
    @(posedge clk); #1 chk("R5 on after edge", {7'b0, dout_oe}, 8'h01);
    @(negedge clk); init_n = 1'b0; addr = AW'(77);
    #1 chk("R7 init ignored mode1", dout, pat(44));
    @(posedge clk); #1 chk("R7 edge wins mode1", dout, pat(77));
    @(negedge clk); init_n = 1'b1;
  endtask

  task automatic t_init();
    set_ctrl(8'h02);
    read_at(123, "R3 mode2");
    @(negedge clk); en = 1'b0;
    #1 chk("R6 en ignored", {7'b0, dout_oe}, 8'h01);
    addr = AW'(200);
    init_n = 1'b0;
    #1 chk("R6 init at once", dout, INIT_B);
    @(posedge clk); #1 chk("R6 init beats edge", dout, INIT_B);
    @(negedge clk); init_n = 1'b1;
    #1 chk("R6 held after release", dout, INIT_B);
    @(posedge clk); #1 chk("R6 edge reloads word", dout, pat(200));
    chk("R6 drive with en low", {7'b0, dout_oe}, 8'h01);
    @(negedge clk); en = 1'b1;
  endtask

  task automatic t_bad_ctrl();
    set_ctrl(8'h07);
    @(negedge clk); en = 1'b0;
    #1 chk("R8 acts as mode0 drive", {7'b0, dout_oe}, 8'h00);
    init_n = 1'b0; addr = AW'(31);
    #1 chk("R8 init ignored", dout, pat(200));
    @(posedge clk); #1 chk("R8 edge read", dout, pat(31));
    @(negedge clk); init_n = 1'b1; en = 1'b1;
    #1 chk("R8 drive back", {7'b0, dout_oe}, 8'h01);
  endtask

  initial begin
    t_reset();
    t_load();
    t_async();
    t_sync();
    t_init();
    t_bad_ctrl();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule